// File: doc/BRIEF.md
# Data cache tag and dirty-bit array with parity error injection

This block holds the tag and modified-state bookkeeping of a small set-associative data cache. Each line stores one tag, a valid bit and four dirty flags, one per doubleword of the line. Every dirty flag has its own parity bit. Four request kinds arrive on one port: a read lookup, a cache-touch that brings a line in on a miss, a store, and a zero-line operation that claims a whole line without fetching it. Line fills are handed to an outside responder through a request/acknowledge pair, and the block accepts nothing else until the acknowledge returns.

Three test controls sit in a small control register. The inject control writes wrong parity onto every dirty flag written while it is set. Together with the spread control it makes all four parity bits of the written line wrong. The force-miss control makes a touch fill even when the line is already present. Two ways of one set can then hold the same tag. A read lookup reports a hit and an error flag. The flag rises when more than one way matches or when a parity bit on a matching way disagrees with its dirty flag.

Top module: `dcache_dirty_par`

## Requirements
- R1: After reset `req_ready` is 1, `fill_req` and `rsp_valid` are 0, and every read lookup misses with no error.
- R2: A touch (`req_op`=1) that misses raises `fill_req` one cycle after acceptance with `fill_addr` equal to the request address. Both hold and `req_ready` stays 0 until `fill_ack`. After that edge the line is valid and its dirty flags are clear.
- R3: A read (`req_op`=0) accepted at an edge gives `rsp_valid` for one cycle after that edge, with `rsp_hit` and `rsp_err`. `rsp_err` is never 1 without `rsp_hit`.
- R4: With control bits 0 and 1 of `ctl_wdata` clear, parity bits equal their dirty flags, and a read of a single-copy line reports no error.
- R5: A write-back store hit (`req_op`=2, `req_wthru`=0) sets the dirty flag selected by address bits [1:0]. With the inject bit (bit 0) set, that flag's parity is written wrong, and a later read reports an error. A later clean store to the same doubleword repairs it.
- R6: A fill completed with the inject bit set, as captured when the touch was accepted, writes wrong parity on all four cleared flags.
- R7: With inject and spread (bit 1) both set, a store writes wrong parity on all four flags of the line. A later clean store to one doubleword leaves the error.
- R8: A store hit with `req_wthru`=1 changes neither dirty flags nor parity, whatever the inject bit says.
- R9: Zero-line (`req_op`=3) sets all four dirty flags of the line, allocating a way without a fill on a miss. Its parity follows the inject rule.
- R10: A touch that hits with force-miss (bit 2) clear starts no fill. With force-miss set, a hitting touch fills anyway, and a later read of that address reports `rsp_hit`=1 and `rsp_err`=1.
- R11: Allocation in each set uses a round-robin way pointer, so a third distinct tag in a two-way set evicts the first.
- R12: A control write (`ctl_we`) affects only requests accepted after the edge that writes it. A request accepted at that same edge uses the old controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Bit 0 inject, bit 1 spread to all four, bit 2 force touch miss |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 touch, 2 store, 3 zero-line |
| req_addr | input | ADDR_W | Tag, set index, doubleword select [1:0] |
| req_wthru | input | 1 | Store targets a write-through page |
| req_ready | output | 1 | Request can be accepted |
| fill_req | output | 1 | Line fill outstanding |
| fill_addr | output | ADDR_W | Address of the line being filled |
| fill_ack | input | 1 | Fill responder done |
| rsp_valid | output | 1 | Read result valid |
| rsp_hit | output | 1 | Read found at least one matching way |
| rsp_err | output | 1 | Multi-hit or dirty parity mismatch |

## Verification
The assertions assume that `fill_ack` only arrives while `fill_req` is high. They also assume that requests wait for `req_ready`, so a fill completion and a new acceptance never share an edge. The bench drives one request at a time from tasks. Each task waits for `req_ready` before raising `req_valid`, and `fill_ack` is pulsed only after `fill_req` has been seen high. Each scenario uses its own set, so corrupted parity from one case never reaches the read of another. Expected read results are queued before each read and compared when `rsp_valid` appears.

// File: rtl/dcache_dirty_par.sv
module dcache_dirty_par #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 3,
  parameter int WAYS  = 2,
  localparam int ADDR_W = TAG_W + IDX_W + 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wthru,
  output logic              req_ready,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_ack,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [1:0] OP_READ = 2'd0, OP_TOUCH = 2'd1, OP_STORE = 2'd2, OP_ZERO = 2'd3;

  logic             vld   [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [3:0]       dty   [SETS][WAYS];
  logic [3:0]       par   [SETS][WAYS];
  logic [WAY_W-1:0] vic   [SETS];

  logic c_inj, c_all, c_fm;
  logic busy, f_inj, f_all;
  logic [ADDR_W-1:0] f_addr;

  logic [TAG_W-1:0] a_tag, f_tag;
  logic [IDX_W-1:0] a_idx, f_idx;
  logic [3:0]       dmask;
  logic             accept;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, f_way;
  logic             par_bad;

  assign a_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign a_idx     = req_addr[2 +: IDX_W];
  assign dmask     = 4'b0001 << req_addr[1:0];
  assign f_tag     = f_addr[ADDR_W-1 -: TAG_W];
  assign f_idx     = f_addr[2 +: IDX_W];
  assign f_way     = vic[f_idx];
  assign req_ready = !busy;
  assign fill_req  = busy;
  assign fill_addr = f_addr;
  assign accept    = req_valid && req_ready;

  always_comb begin
    hit_vec = '0;
    hit_way = '0;
    par_bad = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld[a_idx][w] && (tag_q[a_idx][w] == a_tag);
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
        par_bad = par_bad | (|(dty[a_idx][w] ^ par[a_idx][w]));
      end
    end
  end

  function automatic logic [3:0] new_par(input logic [3:0] d, input logic [3:0] wm,
                                         input logic [3:0] oldp, input logic inj, input logic all);
    logic [3:0] r;
    for (int b = 0; b < 4; b++)
      r[b] = (inj && (all || wm[b])) ? ~d[b] : (wm[b] ? d[b] : oldp[b]);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]   <= 1'b0;
          tag_q[s][w] <= '0;
          dty[s][w]   <= '0;
          par[s][w]   <= '0;
        end
        vic[s] <= '0;
      end
      {c_fm, c_all, c_inj} <= 3'b000;
      busy      <= 1'b0;
      f_inj     <= 1'b0;
      f_all     <= 1'b0;
      f_addr    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (ctl_we) {c_fm, c_all, c_inj} <= ctl_wdata;
      if (busy && fill_ack) begin
        busy                <= 1'b0;
        vld[f_idx][f_way]   <= 1'b1;
        tag_q[f_idx][f_way] <= f_tag;
        dty[f_idx][f_way]   <= 4'h0;
        par[f_idx][f_way]   <= new_par(4'h0, 4'hf, 4'h0, f_inj, f_all);
        vic[f_idx]          <= f_way + 1'b1;
      end
      if (accept) begin
        case (req_op)
          OP_READ: begin
            rsp_valid <= 1'b1;
            rsp_hit   <= |hit_vec;
            rsp_err   <= ($countones(hit_vec) > 1) || par_bad;
          end
          OP_TOUCH: begin
            if (!(|hit_vec) || c_fm) begin
              busy   <= 1'b1;
              f_addr <= req_addr;
              f_inj  <= c_inj;
              f_all  <= c_all;
            end
          end
          OP_STORE: begin
            if ((|hit_vec) && !req_wthru) begin
              dty[a_idx][hit_way] <= dty[a_idx][hit_way] | dmask;
              par[a_idx][hit_way] <= new_par(dty[a_idx][hit_way] | dmask, dmask,
                                             par[a_idx][hit_way], c_inj, c_all);
            end
          end
          default: begin
            if (|hit_vec) begin
              dty[a_idx][hit_way] <= 4'hf;
              par[a_idx][hit_way] <= new_par(4'hf, 4'hf, 4'h0, c_inj, c_all);
            end else begin
              vld[a_idx][vic[a_idx]]   <= 1'b1;
              tag_q[a_idx][vic[a_idx]] <= a_tag;
              dty[a_idx][vic[a_idx]]   <= 4'hf;
              par[a_idx][vic[a_idx]]   <= new_par(4'hf, 4'hf, 4'h0, c_inj, c_all);
              vic[a_idx]               <= vic[a_idx] + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R2
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_addr));
  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);
  // R3
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_op == OP_READ |=> rsp_valid);
  // R3
  err_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_err);
  // R10
  touch_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_op == OP_TOUCH && (|hit_vec) && !c_fm |=> !fill_req);
endmodule

// File: tb/test_dcache_dirty_par.sv
`timescale 1ns/1ps
module test_dcache_dirty_par;
  localparam int ADDR_W = 13;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0; logic [2:0] ctl_wdata = 0;
  logic req_valid = 0; logic [1:0] req_op = 0; logic [ADDR_W-1:0] req_addr = 0; logic req_wthru = 0;
  logic req_ready, fill_req, fill_ack = 0, rsp_valid, rsp_hit, rsp_err;
  logic [ADDR_W-1:0] fill_addr;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] expq[$];
  string      tagq[$];

  dcache_dirty_par i_dcache_dirty_par (.*);

  always #10 clk = ~clk;

  function automatic logic [ADDR_W-1:0] ad(int t, int i, int d);
    return {8'(t), 3'(i), 2'(d)};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) chk("R3 unexpected response", 1, 0);
    else begin
      string t = tagq.pop_front();
      chk(t, {30'd0, rsp_hit, rsp_err}, {30'd0, expq.pop_front()});
    end
  end

  task automatic req(logic [1:0] op, logic [ADDR_W-1:0] a, logic wt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wthru = wt;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic hit, logic err, string r);
    expq.push_back({hit, err}); tagq.push_back(r);
    req(2'd0, a, 0);
  endtask

  task automatic touch(logic [ADDR_W-1:0] a, logic exp_fill, string r);
    req(2'd1, a, 0);
    chk(r, fill_req, exp_fill);
    if (exp_fill) begin
      chk({r, " fill_addr"}, fill_addr, a);
      chk({r, " ready low"}, req_ready, 0);
      @(negedge clk);
      chk({r, " fill held"}, fill_req, 1);
      fill_ack = 1;
      @(negedge clk);
      fill_ack = 0;
      chk({r, " fill done"}, fill_req, 0);
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rd(ad(1, 0, 0), 0, 0, "R1 empty read");

    touch(ad(1, 0, 0), 1, "R2 touch miss");
    rd(ad(1, 0, 0), 1, 0, "R2 R4 filled line");
    touch(ad(1, 0, 0), 0, "R10 touch hit no fill");

    // R12: control write at the same edge as a store
    @(negedge clk);
    ctl_we = 1; ctl_wdata = 3'b001;
    req_valid = 1; req_op = 2'd2; req_addr = ad(1, 0, 1); req_wthru = 0;
    @(negedge clk);
    ctl_we = 0; req_valid = 0;
    ctl(3'b000);
    rd(ad(1, 0, 1), 1, 0, "R12 same-edge control unseen");

    touch(ad(2, 1, 0), 1, "R5 setup");
    ctl(3'b001); req(2'd2, ad(2, 1, 2), 0); ctl(3'b000);
    rd(ad(2, 1, 0), 1, 1, "R5 inject store");

    ctl(3'b001); touch(ad(3, 2, 0), 1, "R6 setup"); ctl(3'b000);
    rd(ad(3, 2, 0), 1, 1, "R6 inject fill");

    touch(ad(4, 3, 0), 1, "R8 setup");
    ctl(3'b001); req(2'd2, ad(4, 3, 0), 1); ctl(3'b000);
    rd(ad(4, 3, 0), 1, 0, "R8 write-through ignored");

    touch(ad(5, 4, 0), 1, "R7 setup");
    ctl(3'b011); req(2'd2, ad(5, 4, 0), 0); ctl(3'b000);
    req(2'd2, ad(5, 4, 0), 0);
    rd(ad(5, 4, 0), 1, 1, "R7 spread survives repair");

    touch(ad(6, 5, 0), 1, "R5 repair setup");
    ctl(3'b001); req(2'd2, ad(6, 5, 0), 0); ctl(3'b000);
    req(2'd2, ad(6, 5, 0), 0);
    rd(ad(6, 5, 0), 1, 0, "R5 clean store repairs");
    req(2'd2, ad(33, 5, 1), 0);
    rd(ad(33, 5, 1), 0, 0, "R5 store miss allocates nothing");

    req(2'd3, ad(7, 6, 0), 0);
    chk("R9 zero-line no fill", fill_req, 0);
    rd(ad(7, 6, 0), 1, 0, "R9 zero-line allocate");
    ctl(3'b001); req(2'd3, ad(7, 6, 0), 0); ctl(3'b000);
    rd(ad(7, 6, 0), 1, 1, "R9 zero-line inject");

    touch(ad(8, 7, 0), 1, "R10 setup");
    ctl(3'b100); touch(ad(8, 7, 0), 1, "R10 forced fill"); ctl(3'b000);
    rd(ad(8, 7, 0), 1, 1, "R10 multi-hit");

    touch(ad(9, 0, 0), 1, "R11 second way");
    rd(ad(9, 0, 0), 1, 0, "R11 tag9 present");
    rd(ad(1, 0, 0), 1, 0, "R11 tag1 kept");
    touch(ad(10, 0, 0), 1, "R11 third tag");
    rd(ad(1, 0, 0), 0, 0, "R11 tag1 evicted");
    rd(ad(9, 0, 0), 1, 0, "R11 tag9 kept");
    rd(ad(10, 0, 0), 1, 0, "R11 tag10 present");

    repeat (3) @(negedge clk);
    chk("R3 all responses seen", expq.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule